// File: doc/BRIEF.md
# Reference Selection and Mode Controller

This block decides which of two reference clock inputs is handed to a downstream timing PLL, and it tells that PLL which operating state to run in: locked to a reference (NORMAL), coasting on its last frequency (HOLDOVER), or running on its local oscillator alone (FREERUN). A two-bit mode input either forces one of the three states by hand or hands control to an internal automatic sequencer. The sequencer watches one loss-of-signal flag per reference.

In the manual modes, the swap input picks the routed reference directly. In automatic mode, the same input only decides which reference is treated as the primary. The sequencer prefers the primary. It falls back to the secondary when the primary fails, and it coasts in HOLDOVER when both references fail. It returns to the primary only after that reference has stayed clean for a qualification window. Every change of the routed reference raises a single-cycle strobe, so that a downstream phase corrector can absorb the phase step. The loss flags are asynchronous and pass through a two-flop synchronizer before they are used.

Top module: `refsel_ctrl`

## Requirements
- R1: One cycle after `mode_sel` is 2'b00, 2'b01 or 2'b10, `pll_state` equals NORMAL (2'b00), HOLDOVER (2'b01) or FREERUN (2'b10) respectively.
- R2: `ref_out` always equals `ref_b` when `sel_b` is 1 and `ref_a` when `sel_b` is 0. In the manual modes, `sel_b` equals `ref_swap` one cycle later.
- R3: In the manual modes, `los_a` and `los_b` have no effect on `pll_state` or `sel_b`.
- R4: After `mode_sel` becomes 2'b11 (automatic), `pll_state` reads FREERUN. It changes to NORMAL on the primary exactly QUAL_CYCLES+3 cycles after the primary's loss flag falls, provided the flag stays low.
- R5: In automatic mode, when the primary's loss flag rises while the secondary's is low, `pll_state` stays NORMAL and `sel_b` moves to the secondary 3 cycles after the flag change. The first two of those cycles are synchronizer latency.
- R6: In automatic mode, with both loss flags high, `pll_state` becomes HOLDOVER 3 cycles after the second flag rises. `sel_b` keeps its last value.
- R7: In automatic mode, while the secondary is in use, the block returns to the primary QUAL_CYCLES+3 cycles after the primary's flag falls. A return shorter than QUAL_CYCLES cycles causes no switch.
- R8: In automatic mode, `ref_swap`=0 makes input A the primary and `ref_swap`=1 makes input B the primary.
- R9: `switch_stb` is high for exactly the one cycle in which `sel_b` takes a new value, and is low at all other times.
- R10: While reset is asserted, `pll_state` is FREERUN, `sel_b` is 0 and `switch_stb` is 0.
- R11: In automatic HOLDOVER, when the secondary's loss flag falls while the primary is still unqualified, the block returns to NORMAL on the secondary 3 cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 00 manual NORMAL, 01 manual HOLDOVER, 10 manual FREERUN, 11 automatic |
| ref_swap | input | 1 | Manual: selects input B. Automatic: makes input B the primary |
| ref_a | input | 1 | Reference input A |
| ref_b | input | 1 | Reference input B |
| los_a | input | 1 | Asynchronous loss-of-signal flag for input A |
| los_b | input | 1 | Asynchronous loss-of-signal flag for input B |
| ref_out | output | 1 | Selected reference routed to the PLL |
| sel_b | output | 1 | 1 when input B is routed |
| pll_state | output | 2 | 00 NORMAL, 01 HOLDOVER, 10 FREERUN |
| switch_stb | output | 1 | One-cycle pulse on each change of the routed reference |

## Verification
The manual codes are stepped through with loss flags toggling underneath them, which separates pin-driven behaviour from sequencer behaviour. In automatic mode, the loss flags are driven through the full sequence: primary acquisition from FREERUN, fallback to the secondary, double loss, secondary recovery, and qualified primary recovery. Each result is sampled on the exact cycle predicted from the synchronizer depth and the qualification count, and also on the cycle before it. A primary return shorter than the qualification window shows that the counter demands consecutive clean cycles. A final pass with the roles swapped shows that the swap bit renames primary and secondary rather than forcing a route. A total pulse count then confirms that a strobe appears on each route change and nowhere else.

// File: rtl/refsel_ctrl.sv
module refsel_ctrl #(
  parameter int QUAL_CYCLES = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       ref_swap,
  input  logic       ref_a,
  input  logic       ref_b,
  input  logic       los_a,
  input  logic       los_b,
  output logic       ref_out,
  output logic       sel_b,
  output logic [1:0] pll_state,
  output logic       switch_stb
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] QUAL_MAX = CW'(QUAL_CYCLES);
  localparam logic [1:0] ST_NORMAL = 2'b00;
  localparam logic [1:0] ST_HOLD   = 2'b01;
  localparam logic [1:0] ST_FREE   = 2'b10;
  localparam logic [1:0] MODE_AUTO = 2'b11;

  typedef enum logic [1:0] {A_FREE, A_PRI, A_SEC, A_HOLD} auto_t;

  logic [1:0]    los_m, los_s;
  logic [CW-1:0] qual_cnt;
  auto_t         fsm, fsm_nx;
  logic [1:0]    state_nx;
  logic          sel_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      los_m <= 2'b11;
      los_s <= 2'b11;
    end else begin
      los_m <= {los_b, los_a};
      los_s <= los_m;
    end

  wire prim_los = ref_swap ? los_s[1] : los_s[0];
  wire sec_los  = ref_swap ? los_s[0] : los_s[1];
  wire qual_ok  = (qual_cnt == QUAL_MAX);
  wire auto_on  = (mode_sel == MODE_AUTO);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          qual_cnt <= '0;
    else if (prim_los)   qual_cnt <= '0;
    else if (!qual_ok)   qual_cnt <= qual_cnt + CW'(1);

  always_comb begin
    fsm_nx = fsm;
    case (fsm)
      A_FREE: if (qual_ok) fsm_nx = A_PRI;
      A_PRI:  if (prim_los) fsm_nx = sec_los ? A_HOLD : A_SEC;
      A_SEC:  if (qual_ok) fsm_nx = A_PRI;
              else if (sec_los) fsm_nx = A_HOLD;
      A_HOLD: if (qual_ok) fsm_nx = A_PRI;
              else if (!sec_los) fsm_nx = A_SEC;
      default: fsm_nx = A_FREE;
    endcase
  end

  always_comb begin
    state_nx = mode_sel;
    sel_nx   = ref_swap;
    if (auto_on)
      case (fsm_nx)
        A_PRI:   begin state_nx = ST_NORMAL; sel_nx = ref_swap;  end
        A_SEC:   begin state_nx = ST_NORMAL; sel_nx = !ref_swap; end
        A_HOLD:  begin state_nx = ST_HOLD;   sel_nx = sel_b;     end
        default: begin state_nx = ST_FREE;   sel_nx = sel_b;     end
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fsm        <= A_FREE;
      pll_state  <= ST_FREE;
      sel_b      <= 1'b0;
      switch_stb <= 1'b0;
    end else begin
      fsm        <= auto_on ? fsm_nx : A_FREE;
      pll_state  <= state_nx;
      sel_b      <= sel_nx;
      switch_stb <= (sel_nx != sel_b);
    end

  assign ref_out = sel_b ? ref_b : ref_a;

  a_r1_manual_state: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_sel) != MODE_AUTO) |-> pll_state == $past(mode_sel));

  a_r2_manual_route: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_sel) != MODE_AUTO) |-> sel_b == $past(ref_swap));

  a_r5_secondary_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm == A_SEC) |-> (pll_state == ST_NORMAL && sel_b == !ref_swap) || $past(ref_swap) != ref_swap);

  a_r6_hold_keeps_route: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && fsm == A_HOLD && $past(fsm) == A_HOLD) |-> $stable(sel_b));

  a_r9_strobe_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && sel_b != $past(sel_b)) |-> switch_stb);
endmodule

// File: tb/refsel_ctrl_bench.sv
module refsel_ctrl_bench;
  localparam int Q = 8;
  localparam logic [1:0] NRM = 2'b00, HLD = 2'b01, FRE = 2'b10;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode_sel = 2'b11;
  logic ref_swap = 0, ref_a = 1, ref_b = 0, los_a = 1, los_b = 1;
  logic ref_out, sel_b, switch_stb;
  logic [1:0] pll_state;

  refsel_ctrl #(.QUAL_CYCLES(Q)) u_refsel_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ref_swap(ref_swap),
    .ref_a(ref_a), .ref_b(ref_b), .los_a(los_a), .los_b(los_b),
    .ref_out(ref_out), .sel_b(sel_b), .pll_state(pll_state), .switch_stb(switch_stb));

  always #5 clk = ~clk;

  typedef struct {
    int due; logic [1:0] st; logic sel; logic stb; string tag;
  } item_t;
  item_t q[$];
  int cyc = 0, vectors = 0, errors = 0, stb_seen = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic compare(input logic [1:0] st, input logic sel, input logic stb, input string tag);
    logic exp_ref;
    exp_ref = sel ? ref_b : ref_a;
    vectors++;
    if (pll_state !== st || sel_b !== sel || switch_stb !== stb || ref_out !== exp_ref) begin
      errors++;
      $display("FAIL %s cyc %0d: state/sel/stb/ref got %b/%b/%b/%b exp %b/%b/%b/%b",
               tag, cyc, pll_state, sel_b, switch_stb, ref_out, st, sel, stb, exp_ref);
    end
  endtask

  task automatic expect_in(input int dly, input logic [1:0] st, input logic sel,
                           input logic stb, input string tag);
    item_t it;
    it.due = cyc + dly; it.st = st; it.sel = sel; it.stb = stb; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && switch_stb) stb_seen++;
    for (int i = q.size() - 1; i >= 0; i--)
      if (q[i].due == cyc) begin
        compare(q[i].st, q[i].sel, q[i].stb, q[i].tag);
        q.delete(i);
      end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    compare(FRE, 0, 0, "R10 reset");
    rst_n = 1;
    tick(1); mode_sel = 2'b00; ref_swap = 0; expect_in(1, NRM, 0, 0, "R1 normal");
    tick(3); ref_swap = 1; expect_in(1, NRM, 1, 1, "R2 R9 manual swap");
    expect_in(2, NRM, 1, 0, "R9 strobe width");
    tick(3); mode_sel = 2'b01; expect_in(1, HLD, 1, 0, "R1 holdover");
    tick(3); mode_sel = 2'b10; expect_in(1, FRE, 1, 0, "R1 freerun");
    tick(3); los_a = 0; los_b = 0;
    expect_in(5, FRE, 1, 0, "R3 loss ignored");
    expect_in(Q + 6, FRE, 1, 0, "R3 loss ignored late");
    tick(Q + 8); los_a = 1; los_b = 1;
    tick(4); mode_sel = 2'b11; ref_swap = 0; expect_in(1, FRE, 1, 0, "R4 auto entry");
    tick(3); los_b = 0; expect_in(5, FRE, 1, 0, "R4 waits for primary");
    tick(6); los_a = 0;
    expect_in(Q + 2, FRE, 1, 0, "R4 before qualify");
    expect_in(Q + 3, NRM, 0, 1, "R4 lock primary");
    expect_in(Q + 4, NRM, 0, 0, "R9 strobe width");
    tick(Q + 6); los_a = 1;
    expect_in(2, NRM, 0, 0, "R5 sync latency");
    expect_in(3, NRM, 1, 1, "R5 fallback");
    tick(5); los_a = 0; tick(4); los_a = 1;
    expect_in(Q + 6, NRM, 1, 0, "R7 short return");
    tick(Q + 8); los_b = 1;
    expect_in(3, HLD, 1, 0, "R6 holdover");
    expect_in(6, HLD, 1, 0, "R6 holdover stays");
    tick(8); los_b = 0; expect_in(3, NRM, 1, 0, "R11 secondary recovery");
    tick(5); los_a = 0;
    expect_in(Q + 2, NRM, 1, 0, "R7 before qualify");
    expect_in(Q + 3, NRM, 0, 1, "R7 primary return");
    tick(Q + 6); ref_swap = 1; expect_in(1, NRM, 1, 1, "R8 role swap");
    tick(4); los_b = 1; expect_in(3, NRM, 0, 1, "R8 swapped fallback");
    tick(5); los_a = 1; expect_in(3, HLD, 0, 0, "R6 swapped holdover");
    tick(6);
    ref_a = 0; ref_b = 1; #1;
    compare(HLD, 0, 0, "R2 ref follow");
    vectors++;
    if (stb_seen != 6) begin
      errors++;
      $display("FAIL R9 strobe count got %0d exp %0d", stb_seen, 6);
    end
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left %0d items exp 0", q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule